// File: doc/BRIEF.md
# Presettable Cascadable Up-Counter Stage

This block is one synchronous up-counting stage, four bits wide by default. A compile-time parameter sets the sequence: either decimal, from 0 to 9, or full binary, from 0 to 15. A second parameter sets how the active-low clear behaves. It either zeroes the count the moment it falls, or it zeroes the count at the next rising clock edge. An active-low load copies a parallel word into the stage at a clock edge.

The stage has two active-high count enables. The stage advances only when both are high. The second enable also gates the terminal-count flag, called the carry output. To build a wider counter, tie the carry output of one stage to the second enable of the next stage. Tie the first enable of every stage to a common run signal. The next stage then steps on the same edge on which the earlier stage wraps.

There is no data stream through the block. All pins are plain control and status levels.

Top module: `ctr_stage`

## Requirements
- R1: With ASYNC_CLR=1, driving clr_n low forces q to 0 without waiting for a clock edge. q stays 0 for as long as clr_n is low.
- R2: With ASYNC_CLR=0, q becomes 0 at the first rising edge at which clr_n is sampled low. Between edges, clr_n has no effect on q.
- R3: Clear has priority over load and over counting. With clr_n low, the next value is 0 whatever ld_n, en_p and en_t are.
- R4: When clr_n is high and ld_n is low at a rising edge, q takes the value of din. Bit 0 of din goes to bit 0 of q. This happens whatever the enables are.
- R5: When clr_n and ld_n are high, q increments at a rising edge only if en_p and en_t are both high. Otherwise q holds its value.
- R6: With DECADE=1, the count wraps from 9 to 0. For example, loading 7 and counting gives 8, 9, 0, 1, 2, 3.
- R7: With DECADE=0, the count wraps from 15 to 0. For example, loading 12 and counting gives 13, 14, 15, 0, 1, 2.
- R8: rco is high exactly when en_t is high and q equals the terminal value. The terminal value is 9 with DECADE=1 and 15 with DECADE=0. en_p and ld_n do not affect rco. rco is combinational and does not wait for a clock edge.
- R9: With DECADE=1, a loaded value from 10 to 15 increments by one on each enabled edge and wraps from 15 to 0. rco stays low while q is in that range.
- R10: Two decimal stages form a 0-to-99 counter when connected as follows. The low stage's rco drives the high stage's en_t. Both stages' en_p come from one run signal. The pair then steps once per enabled edge and wraps from 99 to 0. The high stage's rco is high only at 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel load word, bit 0 least significant |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | WIDTH | Current count |
| rco | output | 1 | Terminal-count carry, gated by en_t |

## Verification
Clear, load and count can all be requested in the same cycle, and clear and load each have to win in turn. Random stimulus makes clr_n and ld_n low together while both enables are high. Directed cases also hold load low while the count sits at its terminal value. The result after each edge is compared with a bench model that applies the priority order. The carry is sampled before each edge, while load or en_p is active. This confirms that neither of them disturbs the carry.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  // Terminal value of a stage for the selected sequence
  function automatic int unsigned term_value(input bit decade, input int unsigned width);
    return decade ? 9 : ((1 << width) - 1);
  endfunction
endpackage

// File: rtl/ctr_term.sv
module ctr_term #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_term,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(ctr_pkg::term_value(DECADE, WIDTH));

  always_comb begin
    at_term = (q == TERM);
    rco     = at_term & en_t;
  end
endmodule

// File: rtl/ctr_next.sv
module ctr_next #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic             at_term,
  output logic [WIDTH-1:0] nxt
);
  // Load beats count, count beats hold; clear is applied by the caller
  always_comb begin
    if (!ld_n)
      nxt = din;
    else if (en_p && en_t)
      nxt = at_term ? '0 : q + WIDTH'(1);
    else
      nxt = q;
  end
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(ctr_pkg::term_value(DECADE, WIDTH));

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             at_term;

  ctr_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .q(cnt_q), .en_t(en_t), .at_term(at_term), .rco(rco)
  );

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .q(cnt_q), .din(din), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .at_term(at_term), .nxt(cnt_nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
      // R1
      aclr_zero_chk: assert property (@(posedge clk) !clr_n |-> cnt_q == '0);
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
      // R2
      sclr_zero_chk: assert property (@(posedge clk) !clr_n |=> cnt_q == '0);
    end
  endgenerate

  assign q = cnt_q;

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (!clr_n || q == $past(din)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> (!clr_n || $stable(q)));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t && q == TERM) |=> (!clr_n || q == '0));
  // R8
  rco_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_t || q != TERM) |-> !rco);
endmodule

// File: tb/ctr_stage_tb.sv
`timescale 1ns/1ps
module ctr_stage_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q_dec, q_bin;
  logic       rco_dec, rco_bin;

  // Chain signals
  logic       c_clr_n = 1'b1, c_ld_n = 1'b1, c_run = 1'b0;
  logic [3:0] c_dlo = '0, c_dhi = '0;
  logic [3:0] q_lo, q_hi;
  logic       rco_lo, rco_hi;

  int checks = 0, failures = 0;
  int m_dec = 0, m_bin = 0, m_chain = 0;

  ctr_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_dec), .rco(rco_dec));
  ctr_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bin (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_bin), .rco(rco_bin));
  ctr_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .din(c_dlo), .en_p(c_run), .en_t(c_run),
    .q(q_lo), .rco(rco_lo));
  ctr_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .din(c_dhi), .en_p(c_run), .en_t(rco_lo),
    .q(q_hi), .rco(rco_hi));

  function automatic int model_next(int cur, bit clr, bit ld, int d, bit p, bit t, bit dec);
    int term = dec ? 9 : 15;
    if (!clr) return 0;
    if (!ld) return d;
    if (p && t) return (cur == term) ? 0 : ((cur + 1) % 16);
    return cur;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock of the single-stage pair; tag names the requirement under test
  task automatic step(bit c, bit l, int d, bit p, bit t, string tag);
    @(negedge clk);
    clr_n = c; ld_n = l; din = 4'(d); en_p = p; en_t = t;
    #0.5;
    if (!c) m_dec = 0;
    chk(!c ? "R1 async clear" : tag, int'(q_dec), m_dec);
    chk((m_dec >= 10) ? "R9 rco decade" : "R8 rco decade", int'(rco_dec), int'(t && m_dec == 9));
    chk("R8 rco binary", int'(rco_bin), int'(t && m_bin == 15));
    @(posedge clk);
    m_dec = model_next(m_dec, c, l, d, p, t, 1'b1);
    m_bin = model_next(m_bin, c, l, d, p, t, 1'b0);
    #0.5;
    chk(!c ? "R3 clear priority decade" : tag, int'(q_dec), m_dec);
    chk(!c ? "R2 sync clear binary" : tag, int'(q_bin), m_bin);
  endtask

  task automatic cstep(bit c, bit l, int d, bit run);
    @(negedge clk);
    c_clr_n = c; c_ld_n = l; c_dlo = 4'(d % 10); c_dhi = 4'(d / 10); c_run = run;
    #0.5;
    if (!c) m_chain = 0;
    chk("R10 chain rco", int'(rco_hi), int'(run && m_chain == 99));
    @(posedge clk);
    if (!c) m_chain = 0;
    else if (!l) m_chain = d;
    else if (run) m_chain = (m_chain + 1) % 100;
    #0.5;
    chk("R10 chain value", int'(q_hi) * 10 + int'(q_lo), m_chain);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 clr_n = 1'b0; c_clr_n = 1'b0;
    #0.5;
    chk("R1 reset async", int'(q_dec), 0);
    @(posedge clk); #0.5;
    chk("R2 reset sync", int'(q_bin), 0);
    m_dec = 0; m_bin = 0;

    // R6 / R7 directed sequences: load 7 (decade) then count; load 12 (binary)
    step(1, 0, 7, 1, 1, "R4 load");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 1, "R6 decade run");
    step(1, 1, 0, 0, 1, "R5 hold en_p low");
    step(1, 1, 0, 1, 0, "R5 hold en_t low");
    step(1, 0, 12, 0, 0, "R4 load with enables low");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 1, "R7 binary run");
    // R8: carry at terminal with load low and en_p low
    step(1, 0, 9, 1, 1, "R4 load 9");
    step(1, 0, 9, 0, 1, "R8 load held at terminal");
    step(1, 1, 0, 0, 1, "R8 en_p low at terminal");
    // R9: out-of-range decade values
    step(1, 0, 13, 1, 1, "R4 load 13");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 1, "R9 decade out of range");
    // R3: clear together with load and count
    step(0, 0, 5, 1, 1, "R3 clear beats load");
    step(1, 0, 10, 1, 1, "R4 bit order 1010");
    step(1, 0, 1, 1, 1, "R4 bit order 0001");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 16) != 0, ($urandom % 8) != 0, int'($urandom % 16),
           ($urandom % 4) != 0, ($urandom % 4) != 0, "R5 random");
    end

    // Chain: clear, count through 99, reload near the top, pause
    cstep(0, 1, 0, 0);
    for (int i = 0; i < 130; i++) cstep(1, 1, 0, 1'b1);
    cstep(1, 0, 97, 1);
    for (int i = 0; i < 5; i++) cstep(1, 1, 0, 1'b1);
    cstep(1, 0, 99, 0);
    cstep(1, 1, 0, 0);
    for (int i = 0; i < 200; i++) cstep(($urandom % 32) != 0, ($urandom % 16) != 0,
                                        int'($urandom % 100), ($urandom % 3) != 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule